// File: doc/BRIEF.md
# Descriptor Entry List Walker

This block steps through a chain of variable-length descriptor entries stored in a byte-wide ROM image and reports each entry it accepts. The ROM is read through a synchronous port with one cycle of latency: the address is presented in one cycle and the byte comes back in the next. Software or a boot sequencer supplies a format revision byte, a 12-bit data length and the highest valid port number, then pulses `start`. The total image size is the data length plus 13. The first entry is at the header offset that the revision selects.

Every entry starts with a length byte, followed by a descriptor byte that gives its class (generic or port), a 6-bit index and a disabled flag. Generic entries are reported as they are. Port entries with an index beyond the configured maximum are stepped over silently. Disabled port entries are reported with their disabled status only. Enabled port entries must be exactly eight bytes long, and their link number and dual-link partner fields are decoded. Each reported entry is presented on a valid/ready output and the walk waits while the consumer holds ready low. Malformed chains (zero length, an entry beginning on the final byte, or an entry running past the image end) stop the walk with a sticky error. A clean end of the chain raises a sticky done.

Top module: `desc_walker`

## Requirements
- R1: After reset `ent_valid`, `done` and `err` are 0 and `err_code` is 0.
- R2: When `fmt_rev` equals 3 the first entry is read at byte offset 16; for every other `fmt_rev` value it is read at offset 22.
- R3: The image size is `data_len` + 13. The walk finishes with `done`=1 and `err`=0 when the next entry position equals the image size, and it finishes at once with no entries when the start offset is already at or beyond the image size.
- R4: The walk stops with `err`=1 and `err_code`=1 (overrun) if an entry length byte is 0, if the entry begins on the last byte of the image, or if position plus length exceeds the image size. An entry ending exactly at the image size is accepted.
- R5: Entry byte 0 is the length; in entry byte 1, bits 5:0 are the index, bit 6 the disabled flag and bit 7 the class (0 generic, 1 port). Generic entries are reported with `ent_type`=0, their index and `ent_disabled`, `ent_link`, `ent_has_dual` and `ent_partner` all 0.
- R6: A port entry whose index is strictly greater than `max_port` is not reported, raises no error (its length is not checked) and the walk continues after it; an index equal to `max_port` is processed.
- R7: A port entry with the disabled flag set is reported with `ent_type`=1, `ent_disabled`=1 and link/partner fields 0, whatever its length.
- R8: An enabled, in-range port entry whose length is not 8 stops the walk with `err`=1 and `err_code`=2.
- R9: For an enabled port entry, entry byte 2 bit 4 drives `ent_link`, byte 2 bit 7 drives `ent_has_dual` and byte 3 bits 5:0 drive `ent_partner`.
- R10: While `ent_valid` is 1 and `ent_ready` is 0 the entry outputs hold steady; the walk advances only after the handshake.
- R11: `done`, `err` and `err_code` keep their values until the next accepted `start`, which clears them; `start` is ignored while a walk is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a walk (accepted only when idle) |
| fmt_rev | input | 8 | Format revision; selects the header offset |
| data_len | input | LEN_W | Data length; image size is this plus 13 |
| max_port | input | 6 | Highest port index that is processed |
| rd_en | output | 1 | ROM read enable |
| rd_addr | output | ADDR_W | ROM byte address |
| rd_data | input | 8 | ROM byte, valid the cycle after the request |
| ent_valid | output | 1 | Entry available |
| ent_ready | input | 1 | Consumer accepts the entry |
| ent_type | output | 1 | 0 generic, 1 port |
| ent_index | output | 6 | Entry index |
| ent_disabled | output | 1 | Port entry marked disabled |
| ent_link | output | 1 | Port link number |
| ent_has_dual | output | 1 | Port has a dual-link partner |
| ent_partner | output | 6 | Dual-link partner port number |
| done | output | 1 | Sticky: walk ended cleanly |
| err | output | 1 | Sticky: walk aborted |
| err_code | output | 2 | 1 overrun, 2 bad port entry length |

## Verification
The hardest situations to reach are those where two guards disagree: an entry on the final byte whose length alone would fit, a port entry whose bad length must be ignored because its index is out of range or it is disabled, and an index exactly equal to the limit. The stimulus builds small ROM images by hand so each such entry sits at a chosen offset, and it walks one image under two revision values and two port limits so that only the selected rule changes the outcome. A separate scenario keeps ready low for several cycles and pulses start during the stall.

// File: rtl/walk_pkg.sv
package walk_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CHK,
      ST_LEN,
      ST_HDR,
      ST_B2,
      ST_B3,
      ST_OUT
   } walk_state_e;

   localparam logic [1:0] ERR_NONE     = 2'd0;
   localparam logic [1:0] ERR_OVERRUN  = 2'd1;
   localparam logic [1:0] ERR_PORT_LEN = 2'd2;

   localparam int IDX_W = 6;
endpackage

// File: rtl/walk_hdr_sel.sv
module walk_hdr_sel #(
   parameter int ADDR_W     = 13,
   parameter int HDR_LEGACY = 22,
   parameter int HDR_NEW    = 16,
   parameter int NEW_REV    = 3
) (
   input  logic [7:0]        rev,
   output logic [ADDR_W-1:0] hdr_size
);
   always_comb begin
      if (rev == 8'(NEW_REV)) hdr_size = ADDR_W'(HDR_NEW);
      else                    hdr_size = ADDR_W'(HDR_LEGACY);
   end
endmodule

// File: rtl/walk_bound_chk.sv
module walk_bound_chk #(
   parameter int ADDR_W = 13
) (
   input  logic [ADDR_W-1:0] pos,
   input  logic [ADDR_W-1:0] size,
   input  logic [7:0]        len,
   output logic              overrun
);
   localparam int SUM_W = ADDR_W + 1;

   logic [SUM_W-1:0] end_pos;
   logic [SUM_W-1:0] last_pos;

   always_comb begin
      end_pos  = {1'b0, pos} + SUM_W'(len);
      last_pos = {1'b0, pos} + SUM_W'(1);
      overrun  = (len == 8'd0) || (last_pos == {1'b0, size}) || (end_pos > {1'b0, size});
   end
endmodule

// File: rtl/walk_entry_class.sv
module walk_entry_class #(
   parameter int PORT_LEN = 8
) (
   input  logic [7:0] desc,
   input  logic [7:0] len,
   input  logic [5:0] max_port,
   output logic       is_port,
   output logic       skip,
   output logic       disabled,
   output logic       bad_len
);
   always_comb begin
      is_port  = desc[7];
      skip     = is_port && (desc[5:0] > max_port);
      disabled = is_port && !skip && desc[6];
      bad_len  = is_port && !skip && !desc[6] && (len != 8'(PORT_LEN));
   end
endmodule

// File: rtl/desc_walker.sv
module desc_walker
   import walk_pkg::*;
#(
   parameter int LEN_W      = 12,
   parameter int DATA_START = 13,
   parameter int HDR_LEGACY = 22,
   parameter int HDR_NEW    = 16,
   parameter int NEW_REV    = 3,
   parameter int PORT_LEN   = 8,
   localparam int ADDR_W    = $clog2((1 << LEN_W) + DATA_START)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [7:0]        fmt_rev,
   input  logic [LEN_W-1:0]  data_len,
   input  logic [IDX_W-1:0]  max_port,
   output logic              rd_en,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic [7:0]        rd_data,
   output logic              ent_valid,
   input  logic              ent_ready,
   output logic              ent_type,
   output logic [IDX_W-1:0]  ent_index,
   output logic              ent_disabled,
   output logic              ent_link,
   output logic              ent_has_dual,
   output logic [IDX_W-1:0]  ent_partner,
   output logic              done,
   output logic              err,
   output logic [1:0]        err_code
);
   // elaboration-time parameter checks
   if (LEN_W < 8 || LEN_W > 16) begin : g_bad_len_w
      $error("desc_walker: LEN_W must lie in 8..16");
   end
   if (PORT_LEN < 4 || PORT_LEN > 255) begin : g_bad_port_len
      $error("desc_walker: PORT_LEN must allow bytes 2 and 3");
   end
   if (HDR_LEGACY < DATA_START || HDR_NEW < DATA_START) begin : g_bad_hdr
      $error("desc_walker: header offsets must not precede the data start");
   end

   walk_state_e      state_q;
   logic [ADDR_W-1:0] pos_q;
   logic [ADDR_W-1:0] size_q;
   logic [7:0]        len_q;
   logic [7:0]        desc_q;
   logic              link_q;
   logic              dual_q;
   logic [IDX_W-1:0]  partner_q;

   logic [ADDR_W-1:0] hdr_size;
   logic [ADDR_W-1:0] next_pos;
   logic              overrun;
   logic              cls_port, cls_skip, cls_dis, cls_bad;

   walk_hdr_sel #(
      .ADDR_W(ADDR_W), .HDR_LEGACY(HDR_LEGACY), .HDR_NEW(HDR_NEW), .NEW_REV(NEW_REV)
   ) i_hdr_sel (
      .rev(fmt_rev), .hdr_size(hdr_size)
   );

   // the length byte arrives in ST_LEN, so it is checked straight off the read port
   walk_bound_chk #(.ADDR_W(ADDR_W)) i_bound (
      .pos(pos_q), .size(size_q), .len(rd_data), .overrun(overrun)
   );

   // the descriptor byte arrives in ST_HDR
   walk_entry_class #(.PORT_LEN(PORT_LEN)) i_class (
      .desc(rd_data), .len(len_q), .max_port(max_port),
      .is_port(cls_port), .skip(cls_skip), .disabled(cls_dis), .bad_len(cls_bad)
   );

   assign next_pos = pos_q + ADDR_W'(len_q);

   always_comb begin
      rd_en   = 1'b0;
      rd_addr = pos_q;
      unique case (state_q)
         ST_CHK: begin rd_en = 1'b1; rd_addr = pos_q;                 end
         ST_LEN: begin rd_en = 1'b1; rd_addr = pos_q + ADDR_W'(1);    end
         ST_HDR: begin rd_en = 1'b1; rd_addr = pos_q + ADDR_W'(2);    end
         ST_B2:  begin rd_en = 1'b1; rd_addr = pos_q + ADDR_W'(3);    end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         pos_q     <= '0;
         size_q    <= '0;
         len_q     <= '0;
         desc_q    <= '0;
         link_q    <= 1'b0;
         dual_q    <= 1'b0;
         partner_q <= '0;
         done      <= 1'b0;
         err       <= 1'b0;
         err_code  <= ERR_NONE;
      end else begin
         unique case (state_q)
            ST_IDLE: if (start) begin
               pos_q    <= hdr_size;
               size_q   <= ADDR_W'(data_len) + ADDR_W'(DATA_START);
               done     <= 1'b0;
               err      <= 1'b0;
               err_code <= ERR_NONE;
               state_q  <= ST_CHK;
            end
            ST_CHK: begin
               if (pos_q >= size_q) begin
                  done    <= 1'b1;
                  state_q <= ST_IDLE;
               end else begin
                  state_q <= ST_LEN;
               end
            end
            ST_LEN: begin
               len_q     <= rd_data;
               link_q    <= 1'b0;
               dual_q    <= 1'b0;
               partner_q <= '0;
               if (overrun) begin
                  err      <= 1'b1;
                  err_code <= ERR_OVERRUN;
                  state_q  <= ST_IDLE;
               end else begin
                  state_q <= ST_HDR;
               end
            end
            ST_HDR: begin
               desc_q <= rd_data;
               if (!cls_port)     state_q <= ST_OUT;
               else if (cls_skip) begin
                  pos_q   <= next_pos;
                  state_q <= ST_CHK;
               end
               else if (cls_dis)  state_q <= ST_OUT;
               else if (cls_bad) begin
                  err      <= 1'b1;
                  err_code <= ERR_PORT_LEN;
                  state_q  <= ST_IDLE;
               end
               else               state_q <= ST_B2;
            end
            ST_B2: begin
               link_q  <= rd_data[4];
               dual_q  <= rd_data[7];
               state_q <= ST_B3;
            end
            ST_B3: begin
               partner_q <= rd_data[IDX_W-1:0];
               state_q   <= ST_OUT;
            end
            ST_OUT: if (ent_ready) begin
               pos_q   <= next_pos;
               state_q <= ST_CHK;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign ent_valid    = (state_q == ST_OUT);
   assign ent_type     = desc_q[7];
   assign ent_index    = desc_q[IDX_W-1:0];
   assign ent_disabled = desc_q[7] & desc_q[6];
   assign ent_link     = link_q;
   assign ent_has_dual = dual_q;
   assign ent_partner  = partner_q;
endmodule

// File: rtl/desc_walker_chk.sv
module desc_walker_chk #(
   parameter int IDX_W = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic             ent_valid,
   input logic             ent_ready,
   input logic             ent_type,
   input logic [IDX_W-1:0] ent_index,
   input logic             ent_disabled,
   input logic             ent_link,
   input logic             ent_has_dual,
   input logic [IDX_W-1:0] ent_partner,
   input logic             done,
   input logic             err,
   input logic [1:0]       err_code
);
   a_r10_hold_entry: assert property (@(posedge clk) disable iff (!rst_n)
      ent_valid && !ent_ready |=> ent_valid && $stable(ent_type) && $stable(ent_index)
         && $stable(ent_disabled) && $stable(ent_link) && $stable(ent_has_dual)
         && $stable(ent_partner));

   a_r11_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      done && !start |=> done);

   a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      err && !start |=> err && $stable(err_code));

   a_r4_end_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && err));

   a_r8_code_set: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> err_code != 2'd0);

   a_r11_quiet_when_ended: assert property (@(posedge clk) disable iff (!rst_n)
      (done || err) |-> !ent_valid);

   a_r7_disabled_clean: assert property (@(posedge clk) disable iff (!rst_n)
      ent_valid && ent_disabled |-> ent_type && !ent_link && !ent_has_dual && ent_partner == '0);

   a_r5_generic_clean: assert property (@(posedge clk) disable iff (!rst_n)
      ent_valid && !ent_type |-> !ent_disabled && !ent_link && !ent_has_dual && ent_partner == '0);
endmodule

bind desc_walker desc_walker_chk #(.IDX_W(walk_pkg::IDX_W)) i_desc_walker_chk (
   .clk(clk), .rst_n(rst_n), .start(start),
   .ent_valid(ent_valid), .ent_ready(ent_ready), .ent_type(ent_type),
   .ent_index(ent_index), .ent_disabled(ent_disabled), .ent_link(ent_link),
   .ent_has_dual(ent_has_dual), .ent_partner(ent_partner),
   .done(done), .err(err), .err_code(err_code)
);

// File: tb/test_desc_walker.sv
`timescale 1ns/1ps
module test_desc_walker;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [7:0]  fmt_rev = 8'd1;
   logic [11:0] data_len = '0;
   logic [5:0]  max_port = 6'd4;
   logic        rd_en;
   logic [12:0] rd_addr;
   logic [7:0]  rd_data;
   logic        ent_valid;
   logic        ent_ready = 1'b1;
   logic        ent_type;
   logic [5:0]  ent_index;
   logic        ent_disabled;
   logic        ent_link;
   logic        ent_has_dual;
   logic [5:0]  ent_partner;
   logic        done;
   logic        err;
   logic [1:0]  err_code;

   int n_checks = 0;
   int n_fails  = 0;
   bit finished = 1'b0;

   logic [7:0]  rom [512];
   logic [15:0] got [16];
   int          n_got;

   always #2 clk = ~clk;

   always_ff @(posedge clk) if (rd_en) rd_data <= rom[rd_addr[8:0]];

   desc_walker i_desc_walker (
      .clk(clk), .rst_n(rst_n), .start(start), .fmt_rev(fmt_rev),
      .data_len(data_len), .max_port(max_port), .rd_en(rd_en),
      .rd_addr(rd_addr), .rd_data(rd_data), .ent_valid(ent_valid),
      .ent_ready(ent_ready), .ent_type(ent_type), .ent_index(ent_index),
      .ent_disabled(ent_disabled), .ent_link(ent_link),
      .ent_has_dual(ent_has_dual), .ent_partner(ent_partner),
      .done(done), .err(err), .err_code(err_code)
   );

   // entry packing: {type, disabled, link, dual, index[5:0], partner[5:0]}
   function automatic logic [15:0] mk(input bit t, input bit d, input bit l,
                                      input bit du, input int idx, input int part);
      return {t, d, l, du, 6'(idx), 6'(part)};
   endfunction

   function automatic logic [15:0] cur_entry();
      return {ent_type, ent_disabled, ent_link, ent_has_dual, ent_index, ent_partner};
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic clear_rom();
      for (int i = 0; i < 512; i++) rom[i] = 8'h00;
   endtask

   task automatic put(input int at, input logic [7:0] b);
      rom[at] = b;
   endtask

   // pulse start, collect entries with ready held high until the walk ends
   task automatic run_walk();
      n_got = 0;
      ent_ready = 1'b1;
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      for (int c = 0; c < 2000; c++) begin
         if (ent_valid && n_got < 16) begin
            got[n_got] = cur_entry();
            n_got++;
         end
         if (done || err) break;
         @(negedge clk);
      end
   endtask

   task automatic t_reset();
      check("R1 valid", 32'(ent_valid), 0);
      check("R1 done", 32'(done), 0);
      check("R1 err", 32'(err), 0);
      check("R1 code", 32'(err_code), 0);
   endtask

   // legacy chain with generic, port, skipped, disabled and generic entries
   task automatic t_legacy_chain();
      clear_rom();
      put(22, 8'd4); put(23, 8'h01);
      put(26, 8'd8); put(27, 8'h82); put(28, 8'h90); put(29, 8'h05);
      put(34, 8'd8); put(35, 8'h89); put(36, 8'h90); put(37, 8'h07);
      put(42, 8'd3); put(43, 8'hC3); put(44, 8'hFF);
      put(45, 8'd2); put(46, 8'h7F);
      fmt_rev = 8'd1; data_len = 12'd34; max_port = 6'd4;
      run_walk();
      check("R3 done", 32'(done), 1);
      check("R3 no err", 32'(err), 0);
      check("R6 count", 32'(n_got), 4);
      check("R5 generic", 32'(got[0]), 32'(mk(0,0,0,0,1,0)));
      check("R9 port fields", 32'(got[1]), 32'(mk(1,0,1,1,2,5)));
      check("R7 disabled", 32'(got[2]), 32'(mk(1,1,0,0,3,0)));
      check("R5 generic bit6 ignored", 32'(got[3]), 32'(mk(0,0,0,0,63,0)));
   endtask

   // new-format header offset versus legacy on the same image
   task automatic t_rev_select();
      clear_rom();
      put(16, 8'd8); put(17, 8'h81); put(18, 8'h10); put(19, 8'h2A);
      fmt_rev = 8'd3; data_len = 12'd11; max_port = 6'd4;
      run_walk();
      check("R2 rev3 done", 32'(done), 1);
      check("R2 rev3 count", 32'(n_got), 1);
      check("R9 link no dual", 32'(got[0]), 32'(mk(1,0,1,0,1,6'h2A)));
      fmt_rev = 8'd0;
      run_walk();
      check("R2 legacy err", 32'(err), 1);
      check("R2 legacy code", 32'(err_code), 1);
      check("R2 legacy count", 32'(n_got), 0);
   endtask

   task automatic t_overrun();
      clear_rom();
      fmt_rev = 8'd1; max_port = 6'd4;
      put(22, 8'd0); put(23, 8'h01);
      data_len = 12'd20;
      run_walk();
      check("R4 zero len err", 32'(err), 1);
      check("R4 zero len code", 32'(err_code), 1);
      put(22, 8'd1);
      data_len = 12'd10;
      run_walk();
      check("R4 last byte err", 32'(err), 1);
      check("R4 last byte code", 32'(err_code), 1);
      put(22, 8'd12);
      data_len = 12'd20;
      run_walk();
      check("R4 past end err", 32'(err), 1);
      check("R4 past end count", 32'(n_got), 0);
      put(22, 8'd11);
      run_walk();
      check("R4 exact fit done", 32'(done), 1);
      check("R4 exact fit err", 32'(err), 0);
      check("R4 exact fit count", 32'(n_got), 1);
   endtask

   task automatic t_port_len();
      clear_rom();
      fmt_rev = 8'd1;
      put(22, 8'd7); put(23, 8'hC1);
      put(29, 8'd7); put(30, 8'h85);
      data_len = 12'd23;
      max_port = 6'd4;
      run_walk();
      check("R6 skip no err", 32'(err), 0);
      check("R6 skip done", 32'(done), 1);
      check("R7 short disabled ok", 32'(n_got), 1);
      check("R7 short disabled entry", 32'(got[0]), 32'(mk(1,1,0,0,1,0)));
      max_port = 6'd5;
      run_walk();
      check("R8 bad len err", 32'(err), 1);
      check("R8 bad len code", 32'(err_code), 2);
      check("R6 index at limit processed", 32'(n_got), 1);
   endtask

   task automatic t_empty();
      fmt_rev = 8'd1;
      data_len = 12'd0;
      run_walk();
      check("R3 empty done", 32'(done), 1);
      check("R3 empty count", 32'(n_got), 0);
      data_len = 12'd9;
      run_walk();
      check("R3 start at end done", 32'(done), 1);
      check("R3 start at end count", 32'(n_got), 0);
   endtask

   task automatic t_stall();
      logic [15:0] first;
      int seen;
      clear_rom();
      put(16, 8'd8); put(17, 8'h81); put(18, 8'h90); put(19, 8'h03);
      fmt_rev = 8'd3; data_len = 12'd11; max_port = 6'd4;
      ent_ready = 1'b0;
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      seen = 0;
      for (int c = 0; c < 50 && !ent_valid; c++) @(negedge clk);
      check("R10 valid raised", 32'(ent_valid), 1);
      first = cur_entry();
      for (int c = 0; c < 6; c++) begin
         start = (c == 2);
         @(negedge clk);
         if (ent_valid && cur_entry() == first) seen++;
      end
      start = 1'b0;
      check("R10 held during stall", 32'(seen), 6);
      check("R11 start ignored while busy", 32'(done), 0);
      ent_ready = 1'b1;
      @(negedge clk);
      check("R10 released", 32'(ent_valid), 0);
      for (int c = 0; c < 10 && !done; c++) @(negedge clk);
      check("R10 stall entry", 32'(first), 32'(mk(1,0,1,1,1,3)));
      check("R10 done after release", 32'(done), 1);
   endtask

   task automatic t_sticky();
      repeat (10) @(negedge clk);
      check("R11 done sticky", 32'(done), 1);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check("R11 done cleared", 32'(done), 0);
      for (int c = 0; c < 50 && !(done || err); c++) @(negedge clk);
      fmt_rev = 8'd1; data_len = 12'd20; clear_rom();
      run_walk();
      repeat (8) @(negedge clk);
      check("R11 err sticky", 32'(err), 1);
      check("R11 code sticky", 32'(err_code), 1);
      fmt_rev = 8'd1; data_len = 12'd0;
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      check("R11 err cleared", 32'(err), 0);
      check("R11 code cleared", 32'(err_code), 0);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      clear_rom();
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_legacy_chain();
      t_rev_select();
      t_overrun();
      t_port_len();
      t_empty();
      t_stall();
      t_sticky();
      repeat (4) @(negedge clk);
      finish_run();
   end
endmodule